// File: doc/BRIEF.md
# Double-Data-Rate Read Capture with Clock-Domain Resynchronizer

This block takes the read data returned by an external memory on a double-data-rate DQ bus and delivers it as wide words in the system clock domain. Sampling is timed by a capture clock from outside the block, typically a phase-shifted PLL output, and not by the memory's read strobe. Because of this the block carries no strobe gating and no postamble filtering.

In each capture-clock period the bus is sampled twice: once on the rising edge and once on the falling edge. The falling-edge sample is moved onto the rising edge by an extra register, so both halves are presented together. The pair then goes through a high and a low staging register and into a small asynchronous FIFO with Gray-coded pointers. A consumer in the system domain pulls words out with a ready signal. Each word comes out with a single-cycle valid pulse.

Words are written only while the capture-side read-enable is high. If a write arrives while the FIFO is full, the word is discarded and a sticky overflow indicator is raised.

Top module: `ddr_rdcap`

## Requirements
- R1: The DQ value present at a rising edge of `cap_clk` is delivered on `hi_o`, which is the upper half of the stored entry.
- R2: The DQ value present at the falling edge just before that rising edge is delivered on `lo_o` in the same output word as the R1 value.
- R3: Words leave in the order they were captured. No word is duplicated, and no word is lost while the FIFO has room.
- R4: A pair is stored only if `rd_en_i` is high at the rising edge that samples its high half. Pairs sampled with `rd_en_i` low never appear at the output.
- R5: `valid_o` pulses for exactly one `sys_clk` cycle per delivered word. It is high only after a cycle in which `rdy_i` was high and the FIFO held data.
- R6: A write attempted while the FIFO is full is dropped, and `overflow_o` goes high. `overflow_o` stays high until `cap_rst_n` is asserted.
- R7: After reset, `valid_o`, `hi_o`, `lo_o` and `overflow_o` are all zero, and the FIFO is empty.
- R8: With the consumer stalled, the FIFO holds exactly `DEPTH` (default 8) words. All of them come out intact once `rdy_i` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cap_clk | input | 1 | Capture clock from an external PLL |
| cap_rst_n | input | 1 | Active-low asynchronous reset, capture domain |
| dq_i | input | DQ_W | DDR read data bus |
| rd_en_i | input | 1 | Capture-domain read-enable; qualifies the high sample taken at the same rising edge |
| overflow_o | output | 1 | Sticky flag, set when a word is dropped because the FIFO is full |
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Active-low asynchronous reset, system domain |
| rdy_i | input | 1 | Consumer ready |
| hi_o | output | DQ_W | Rising-edge half of the delivered word |
| lo_o | output | DQ_W | Falling-edge half of the delivered word |
| valid_o | output | 1 | One-cycle pulse per delivered word |

## Verification
The bench runs four patterns.

An incrementing pattern gives distinct values to the two halves of every pair, so a swapped or mispaired half, or a skipped word, shows up as a mismatch.

A walking-one high half paired with its complement in the low half tells apart a bit lost in the DDR capture path from a word lost in the FIFO.

A burst with the read-enable toggled on alternate pairs shows whether disabled samples leak into the stream.

A stalled-consumer burst of eleven pairs separates the eight words that must be kept from the three that must be dropped. It also checks that the overflow flag rises and that nothing is delivered while the consumer is not ready.

// File: rtl/ddrcap_pkg.sv
package ddrcap_pkg;
   // Binary to reflected Gray code, up to 32 bits.
   function automatic logic [31:0] bin2gray(input logic [31:0] b);
      return b ^ (b >> 1);
   endfunction
endpackage

// File: rtl/ddrcap_sync.sv
module ddrcap_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st [STAGES];

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) st[0] <= '0;
               else        st[0] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) st[i] <= '0;
               else        st[i] <= st[i-1];
         end
      end
   endgenerate

   assign q = st[STAGES-1];
endmodule

// File: rtl/ddrcap_iocap.sv
module ddrcap_iocap #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] dq,
   input  logic         en,
   output logic [W-1:0] hi,
   output logic [W-1:0] lo,
   output logic         en_out
);
   logic [W-1:0] rise_q, fall_q, align_q;
   logic         en_q;

   // rising-edge sample and its qualifier
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         rise_q <= '0;
         en_q   <= 1'b0;
      end else begin
         rise_q <= dq;
         en_q   <= en;
      end

   // falling-edge sample
   always_ff @(negedge clk or negedge rst_n)
      if (!rst_n) fall_q <= '0;
      else        fall_q <= dq;

   // move falling sample onto rising edge, then stage both halves
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         align_q <= '0;
         hi      <= '0;
         lo      <= '0;
         en_out  <= 1'b0;
      end else begin
         align_q <= fall_q;
         hi      <= rise_q;
         lo      <= align_q;
         en_out  <= en_q;
      end
endmodule

// File: rtl/ddrcap_afifo.sv
module ddrcap_afifo
   import ddrcap_pkg::*;
#(
   parameter int DW     = 16,
   parameter int DEPTH  = 8,
   parameter int STAGES = 2
) (
   input  logic          wclk,
   input  logic          wrst_n,
   input  logic          wreq,
   input  logic [DW-1:0] wdata,
   output logic          full,
   output logic          drop,
   input  logic          rclk,
   input  logic          rrst_n,
   input  logic          rdy,
   output logic [DW-1:0] rdata,
   output logic          rvalid,
   output logic          empty
);
   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;

   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] wbin, wgray, rbin, rgray, wgray_s, rgray_s;
   logic          push;

   assign full  = (wgray == {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]});
   assign push  = wreq && !full;
   assign drop  = wreq && full;
   assign empty = (rgray == wgray_s);

   always_ff @(posedge wclk or negedge wrst_n)
      if (!wrst_n) begin
         wbin  <= '0;
         wgray <= '0;
      end else if (push) begin
         wbin  <= wbin + 1'b1;
         wgray <= PW'(bin2gray(32'(wbin + 1'b1)));
      end

   always_ff @(posedge wclk)
      if (push) mem[wbin[AW-1:0]] <= wdata;

   always_ff @(posedge rclk or negedge rrst_n)
      if (!rrst_n) begin
         rbin   <= '0;
         rgray  <= '0;
         rdata  <= '0;
         rvalid <= 1'b0;
      end else begin
         rvalid <= 1'b0;
         if (rdy && !empty) begin
            rdata  <= mem[rbin[AW-1:0]];
            rvalid <= 1'b1;
            rbin   <= rbin + 1'b1;
            rgray  <= PW'(bin2gray(32'(rbin + 1'b1)));
         end
      end

   ddrcap_sync #(.W(PW), .STAGES(STAGES)) u_w2r (
      .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_s));
   ddrcap_sync #(.W(PW), .STAGES(STAGES)) u_r2w (
      .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_s));
endmodule

// File: rtl/ddr_rdcap.sv
module ddr_rdcap #(
   parameter int DQ_W   = 8,
   parameter int DEPTH  = 8,
   parameter int STAGES = 2
) (
   input  logic            cap_clk,
   input  logic            cap_rst_n,
   input  logic [DQ_W-1:0] dq_i,
   input  logic            rd_en_i,
   output logic            overflow_o,
   input  logic            sys_clk,
   input  logic            sys_rst_n,
   input  logic            rdy_i,
   output logic [DQ_W-1:0] hi_o,
   output logic [DQ_W-1:0] lo_o,
   output logic            valid_o
);
   localparam int EW = 2 * DQ_W;

   generate
      if (DQ_W < 1) begin : g_bad_width
         $error("ddr_rdcap: DQ_W must be at least 1");
      end
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("ddr_rdcap: DEPTH must be a power of two, at least 4");
      end
      if (STAGES < 2) begin : g_bad_sync
         $error("ddr_rdcap: STAGES must be at least 2");
      end
   endgenerate

   logic [DQ_W-1:0] cap_hi, cap_lo;
   logic            cap_en, fifo_full, fifo_drop, fifo_empty;
   logic [EW-1:0]   rd_word;

   ddrcap_iocap #(.W(DQ_W)) u_cap (
      .clk(cap_clk), .rst_n(cap_rst_n), .dq(dq_i), .en(rd_en_i),
      .hi(cap_hi), .lo(cap_lo), .en_out(cap_en));

   ddrcap_afifo #(.DW(EW), .DEPTH(DEPTH), .STAGES(STAGES)) u_fifo (
      .wclk(cap_clk), .wrst_n(cap_rst_n), .wreq(cap_en),
      .wdata({cap_hi, cap_lo}), .full(fifo_full), .drop(fifo_drop),
      .rclk(sys_clk), .rrst_n(sys_rst_n), .rdy(rdy_i),
      .rdata(rd_word), .rvalid(valid_o), .empty(fifo_empty));

   always_ff @(posedge cap_clk or negedge cap_rst_n)
      if (!cap_rst_n)     overflow_o <= 1'b0;
      else if (fifo_drop) overflow_o <= 1'b1;

   assign hi_o = rd_word[EW-1:DQ_W];
   assign lo_o = rd_word[DQ_W-1:0];
endmodule

// File: rtl/ddrcap_chk.sv
module ddrcap_chk (
   input logic cap_clk,
   input logic cap_rst_n,
   input logic sys_clk,
   input logic sys_rst_n,
   input logic rdy_i,
   input logic valid_o,
   input logic overflow_o,
   input logic wr_req,
   input logic wr_full,
   input logic rd_empty
);
   AST_NO_VALID_WHEN_STALLED: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      !rdy_i |=> !valid_o);                                                // R5
   AST_NO_VALID_WHEN_EMPTY: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      rd_empty |=> !valid_o);                                              // R5
   AST_OVF_ON_DROP: assert property (@(posedge cap_clk) disable iff (!cap_rst_n)
      (wr_req && wr_full) |=> overflow_o);                                 // R6
   AST_OVF_STICKY: assert property (@(posedge cap_clk) disable iff (!cap_rst_n)
      overflow_o |=> overflow_o);                                          // R6
   AST_OVF_ONLY_ON_DROP: assert property (@(posedge cap_clk) disable iff (!cap_rst_n)
      $rose(overflow_o) |-> $past(wr_req && wr_full));                     // R6
endmodule

bind ddr_rdcap ddrcap_chk u_chk (
   .cap_clk(cap_clk), .cap_rst_n(cap_rst_n), .sys_clk(sys_clk),
   .sys_rst_n(sys_rst_n), .rdy_i(rdy_i), .valid_o(valid_o),
   .overflow_o(overflow_o), .wr_req(cap_en), .wr_full(fifo_full),
   .rd_empty(fifo_empty));

// File: tb/ddr_rdcap_tb.sv
`timescale 1ns/1ps
module ddr_rdcap_tb;
   localparam int W = 8;

   logic         cap_clk = 1'b0, sys_clk = 1'b0;
   logic         cap_rst_n = 1'b0, sys_rst_n = 1'b0;
   logic [W-1:0] dq_i = '0;
   logic         rd_en_i = 1'b0, rdy_i = 1'b0;
   logic         overflow_o, valid_o;
   logic [W-1:0] hi_o, lo_o;

   int errors = 0, checks = 0, popped = 0, stall_valids = 0;
   logic [2*W-1:0] exp_q[$];

   always #4 cap_clk = ~cap_clk;   // unrelated capture clock
   always #5 sys_clk = ~sys_clk;   // 100 MHz system clock

   ddr_rdcap #(.DQ_W(W)) u_dut (
      .cap_clk(cap_clk), .cap_rst_n(cap_rst_n), .dq_i(dq_i), .rd_en_i(rd_en_i),
      .overflow_o(overflow_o), .sys_clk(sys_clk), .sys_rst_n(sys_rst_n),
      .rdy_i(rdy_i), .hi_o(hi_o), .lo_o(lo_o), .valid_o(valid_o));

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Drive one DDR pair: lo is on the bus at the falling edge, hi at the next rising edge.
   task automatic beat(input logic [W-1:0] h, input logic [W-1:0] l, input bit en, input bit keep);
      @(posedge cap_clk); #2;
      dq_i = l;
      @(negedge cap_clk); #2;
      dq_i    = h;
      rd_en_i = en;
      if (en && keep) exp_q.push_back({h, l});
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) beat('0, '0, 1'b0, 1'b0);
   endtask

   // monitor / scoreboard
   always @(negedge sys_clk) begin
      if (sys_rst_n && valid_o) begin
         popped++;
         if (!rdy_i) stall_valids++;
         if (exp_q.size() == 0) begin
            check(1'b0, "R4 unexpected word", {16'h0, hi_o, lo_o}, 32'h0);
         end else begin
            logic [2*W-1:0] e;
            e = exp_q.pop_front();
            check(hi_o == e[2*W-1:W], "R1 high half", 32'(hi_o), 32'(e[2*W-1:W]));
            check(lo_o == e[W-1:0],   "R2 low half",  32'(lo_o), 32'(e[W-1:0]));
         end
      end
   end

   bit finished = 1'b0;
   initial begin
      #1_500_000;
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge sys_clk);
      #1;
      check(valid_o == 1'b0, "R7 valid after reset", 32'(valid_o), 0);
      check(overflow_o == 1'b0, "R7 overflow after reset", 32'(overflow_o), 0);
      check({hi_o, lo_o} == '0, "R7 data after reset", 32'({hi_o, lo_o}), 0);
      cap_rst_n = 1'b1;
      sys_rst_n = 1'b1;
      rdy_i     = 1'b1;
      idle(4);
      check(popped == 0, "R7 fifo empty after reset", 32'(popped), 0);

      // incrementing pairs (R1 R2 R3)
      for (int i = 0; i < 20; i++) beat(W'(2*i+1), W'(2*i), 1'b1, 1'b1);
      idle(30);
      check(exp_q.size() == 0, "R3 incrementing stream drained", 32'(exp_q.size()), 0);

      // walking one against its complement
      for (int i = 0; i < W; i++) beat(W'(1 << i), ~W'(1 << i), 1'b1, 1'b1);
      idle(30);
      check(exp_q.size() == 0, "R3 walking stream drained", 32'(exp_q.size()), 0);

      // enable toggled on alternate pairs (R4)
      for (int i = 0; i < 16; i++) beat(W'(8'hC0 + i), W'(8'h30 + i), (i % 2) == 0, 1'b1);
      idle(30);
      check(exp_q.size() == 0, "R4 gated stream drained", 32'(exp_q.size()), 0);
      check(overflow_o == 1'b0, "R6 no overflow before fill", 32'(overflow_o), 0);

      // stalled consumer: 11 writes, first 8 kept (R8, R6)
      rdy_i = 1'b0;
      popped = 0;
      idle(10);
      for (int i = 0; i < 11; i++) beat(W'(8'hA0 + i), W'(8'h50 + i), 1'b1, i < 8);
      idle(10);
      check(overflow_o == 1'b1, "R6 overflow set on drop", 32'(overflow_o), 1);
      check(popped == 0, "R5 no valid while stalled", 32'(popped), 0);
      check(stall_valids == 0, "R5 valid with rdy low", 32'(stall_valids), 0);
      rdy_i = 1'b1;
      idle(30);
      check(popped == 8, "R8 depth words delivered", 32'(popped), 8);
      check(exp_q.size() == 0, "R3 stalled stream drained", 32'(exp_q.size()), 0);
      check(overflow_o == 1'b1, "R6 overflow sticky", 32'(overflow_o), 1);

      // reset clears the sticky flag (R6 R7)
      @(negedge cap_clk);
      cap_rst_n = 1'b0;
      sys_rst_n = 1'b0;
      #1;
      check(overflow_o == 1'b0, "R6 overflow cleared by reset", 32'(overflow_o), 0);
      check(valid_o == 1'b0, "R7 valid cleared by reset", 32'(valid_o), 0);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule